// File: doc/BRIEF.md
# Frame Port NIC

This block is a memory-mapped network peripheral that moves Ethernet-sized frames between a CPU register port and two byte streams. The CPU transmits a frame in three steps. It writes the frame length to a length register. It then writes the bytes one at a time to a data register. Once the last byte is in, the block streams the frame out with no further command. Received frames arrive on an input byte stream and are stored in a receive buffer. The CPU reads them back one byte per access from a receive data register, and a count register shows how many bytes remain.

A single interrupt control register holds three flags: transmit done, receive done and a self-test bit. Writing this register acknowledges a flag or soft-resets the block; which action happens is decided by bit priority. Reading it clears the self-test bit. A busy flag stops new receive frames from being accepted until software has acknowledged the previous events. One level-sensitive interrupt line is high whenever any of the three flags is set.

The CPU port is a single-cycle register bus with a select, a write enable, a 6-bit byte address and 32-bit write data. Read data is registered and valid on the cycle after the read strobe. The input stream has no ready signal, so the block takes one byte on every cycle that valid is high. The output stream uses a valid/ready handshake with a last marker.

Top module: `frame_port_nic`

## Requirements
- R1: After reset, busy (offset 0x08, bit 0) reads 1. Receive count (0x0C), transmit count (0x10) and interrupt control (0x14) read 0, and `irq` is low.
- R2: Fixed reads: offset 0x00 reads 0x424E4943 and offset 0x04 reads 0x50525430. Offsets 0x18 and 0x20 read 0, and so does any unmapped offset. Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change no state.
- R3: The accept decision for an incoming frame is made at its first byte. The frame is taken only if busy is 0 at that byte. Otherwise the whole frame, up to and including its last byte, is discarded and the receive count is unchanged.
- R4: When an accepted frame of L bytes ends, with L below 1514, three things happen. The receive count becomes L. The read position returns to the first byte. Receive-done (bit 1 of 0x14) and busy are both set.
- R5: An accepted frame of 1514 bytes or more is dropped. Receive-done is not raised and the receive count is not changed.
- R6: A read of receive data (0x1C) with a nonzero count returns the next stored byte in bits 7:0, in arrival order, and decrements the count by one. With a count of zero it returns 0 and changes nothing.
- R7: A write of value V to transmit count (0x10) stores V if V is at most 1514 and stores 0 otherwise. In both cases the transmit write position restarts at the first byte.
- R8: Each write to transmit data (0x20) stores bits 7:0 of the write data. The frame is sent once the bytes written equal the stored count, or once 1514 bytes have been written. It leaves on the output stream in write order, with last marking the final byte. Data is held under backpressure. Writes to 0x10 and 0x20 are ignored while a send is in progress.
- R9: After the final byte of a send is accepted by the output stream, transmit count reads 0, transmit-done (bit 0 of 0x14) is set, and busy is set.
- R10: A write to 0x14 takes only the first matching action. Bit 0 set clears transmit-done. Otherwise, bit 1 set clears receive-done. Otherwise, bit 31 set soft-resets all counts, positions and flags and then sets the test bit (bit 31). A value of 0 changes no flag. After the write, busy equals the OR of the remaining flags.
- R11: A read of 0x14 returns {test, 29 zero bits, receive-done, transmit-done} and then clears the test bit.
- R12: `irq` is high exactly when at least one of the three interrupt-control flags is set.
- R13: A read of 0x1C has side effects only when `bus_sel` is 1 and `bus_we` is 0. An access without select, or a write to that offset, leaves the receive count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid on the cycle after the read |
| irq | output | 1 | Level interrupt, high while any flag is set |
| rxs_valid | input | 1 | Receive stream byte valid |
| rxs_data | input | 8 | Receive stream byte |
| rxs_last | input | 1 | Marks the final byte of a received frame |
| txs_valid | output | 1 | Transmit stream byte valid |
| txs_data | output | 8 | Transmit stream byte |
| txs_last | output | 1 | Marks the final byte of a transmitted frame |
| txs_ready | input | 1 | Transmit stream sink ready |

## Verification
Some properties are checked by assertions on every cycle:
- a receive commit or transmit completion raises its flag and busy on the next cycle;
- a read of interrupt control clears the test bit, and an acknowledge clears its flag;
- the receive count stays below the frame limit and steps down by exactly one per qualified data read;
- an unqualified access leaves the count alone;
- the output stream holds its byte and last marker while ready is low;
- a send completion clears the transmit count.

Other behaviour needs whole scenarios, so only the bench shows it. This covers the byte order of a received frame as read back through the register port and the byte order of a transmitted frame on the stream. It also covers refusal of a frame that arrives while busy is set, the silent drop of an overlong frame against the accepted 1513-byte boundary case, the priority among simultaneous acknowledge bits, and the automatic send after 1514 writes when the programmed count is zero.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  localparam int unsigned FRAME_MAX_DEF = 1514;
  localparam int unsigned ADDR_W        = 6;

  localparam logic [ADDR_W-1:0] OFS_ID_HI    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_ID_LO    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_BUSY     = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RX_CNT   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TX_CNT   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IRQ_CTL  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IRQ_INFO = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RX_DATA  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TX_DATA  = 6'h20;

  localparam logic [31:0] ID_HI_WORD = 32'h424E_4943;
  localparam logic [31:0] ID_LO_WORD = 32'h5052_5430;

  typedef struct packed {
    logic test;
    logic rxd;
    logic txd;
  } irq_flags_t;

endpackage

// File: rtl/fpn_rst_sync.sv
module fpn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/fpn_irq_ctl.sv
module fpn_irq_ctl
  import fpn_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        ctl_rd,
  input  logic [2:0]  ctl_cmd,     // {bit31, bit1, bit0} of write data
  input  logic        rx_commit,
  input  logic        tx_done,
  output logic        busy,
  output logic        irq,
  output logic [31:0] ctl_word,
  output logic        soft_clr
);

  irq_flags_t flg_q, flg_d;
  logic       busy_q, busy_d;
  logic       wr_tx, wr_rx, wr_rst, upd_en;

  always_comb begin
    wr_tx  = ctl_wr &  ctl_cmd[0];
    wr_rx  = ctl_wr & ~ctl_cmd[0] &  ctl_cmd[1];
    wr_rst = ctl_wr & ~ctl_cmd[0] & ~ctl_cmd[1] & ctl_cmd[2];
    upd_en = ctl_wr | ctl_rd | rx_commit | tx_done;
  end

  // CPU effect first, hardware events last so they are never lost
  always_comb begin
    flg_d  = flg_q;
    busy_d = busy_q;
    if (ctl_rd) flg_d.test = 1'b0;
    if (wr_tx)  flg_d.txd  = 1'b0;
    if (wr_rx)  flg_d.rxd  = 1'b0;
    if (wr_rst) flg_d      = '{test: 1'b1, rxd: 1'b0, txd: 1'b0};
    if (ctl_wr) busy_d     = |flg_d;
    if (rx_commit) begin
      flg_d.rxd = 1'b1;
      busy_d    = 1'b1;
    end
    if (tx_done) begin
      flg_d.txd = 1'b1;
      busy_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q  <= '0;
      busy_q <= 1'b1;
    end else if (upd_en) begin
      flg_q  <= flg_d;
      busy_q <= busy_d;
    end
  end

  assign busy     = busy_q;
  assign irq      = |flg_q;
  assign ctl_word = {flg_q.test, 29'd0, flg_q.rxd, flg_q.txd};
  assign soft_clr = wr_rst;

  // R4
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_commit |=> flg_q.rxd && busy_q);

  // R9
  tx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> flg_q.txd && busy_q);

  // R10
  ack_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_cmd[0] && !tx_done) |=> !flg_q.txd);

  // R10
  selftest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_cmd == 3'b100) |=> flg_q.test && busy_q && !flg_q.rxd && !flg_q.txd);

  // R11
  test_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !ctl_wr) |=> !flg_q.test);

endmodule

// File: rtl/fpn_rx_buf.sv
module fpn_rx_buf #(
  parameter int unsigned FRAME_MAX = 1514,
  parameter int unsigned CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          busy,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rd_take,
  output logic          commit,
  output logic [CW-1:0] rx_cnt,
  output logic [7:0]    rd_byte
);

  localparam logic [CW-1:0] MAX_CNT  = CW'(FRAME_MAX);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_MAX - 1);

  logic [7:0]    mem [FRAME_MAX];
  logic          in_frame_q, in_frame_d;
  logic          keep_q, keep_d;
  logic          ovr_q, ovr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ptr_q, ptr_d;

  logic          first, keep_now, room, ovr_now, mem_we;
  logic [CW-1:0] idx_now;

  always_comb begin
    first    = ~in_frame_q;
    keep_now = first ? (~busy & (cnt_q < MAX_CNT)) : keep_q;
    idx_now  = first ? '0 : fill_q;
    room     = idx_now < LAST_IDX;
    ovr_now  = (~first & ovr_q) | ~room;
    mem_we   = rx_valid & keep_now & room & ~soft_clr;
    commit   = rx_valid & rx_last & keep_now & ~ovr_now & ~soft_clr;
  end

  always_comb begin
    in_frame_d = in_frame_q;
    keep_d     = keep_q;
    ovr_d      = ovr_q;
    fill_d     = fill_q;
    cnt_d      = cnt_q;
    ptr_d      = ptr_q;
    if (rx_valid) begin
      in_frame_d = ~rx_last;
      keep_d     = keep_now;
      ovr_d      = ovr_now;
      fill_d     = room ? idx_now + 1'b1 : idx_now;
    end
    if (rd_take && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      ptr_d = ptr_q + 1'b1;
    end
    if (commit) begin
      cnt_d = idx_now + 1'b1;
      ptr_d = '0;
    end
    if (soft_clr) begin
      in_frame_d = 1'b0;
      keep_d     = 1'b0;
      ovr_d      = 1'b0;
      fill_d     = '0;
      cnt_d      = '0;
      ptr_d      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      keep_q     <= 1'b0;
      ovr_q      <= 1'b0;
      fill_q     <= '0;
      cnt_q      <= '0;
      ptr_q      <= '0;
    end else begin
      in_frame_q <= in_frame_d;
      keep_q     <= keep_d;
      ovr_q      <= ovr_d;
      fill_q     <= fill_d;
      cnt_q      <= cnt_d;
      ptr_q      <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[idx_now] <= rx_data;
  end

  assign rx_cnt  = cnt_q;
  assign rd_byte = (cnt_q != '0) ? mem[ptr_q] : 8'h00;

  // R5
  rx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < MAX_CNT);

  // R6
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && cnt_q != '0 && !commit && !soft_clr) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6
  rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && cnt_q == '0 && !commit && !soft_clr) |=> cnt_q == '0);

endmodule

// File: rtl/fpn_tx_buf.sv
module fpn_tx_buf #(
  parameter int unsigned FRAME_MAX = 1514,
  parameter int unsigned CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          cnt_wr,
  input  logic          data_wr,
  input  logic [31:0]   wdata,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          done,
  output logic [CW-1:0] tx_cnt
);

  localparam logic [CW-1:0] MAX_CNT = CW'(FRAME_MAX);

  logic [7:0]    mem [FRAME_MAX];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] wr_q, wr_d;
  logic [CW-1:0] len_q, len_d;
  logic [CW-1:0] snd_q, snd_d;
  logic          send_q, send_d;

  logic [CW-1:0] nxt_wr;
  logic          hit, last_beat, mem_we, acc_wr;

  always_comb begin
    nxt_wr    = wr_q + 1'b1;
    hit       = (nxt_wr == cnt_q) || (nxt_wr >= MAX_CNT);
    last_beat = snd_q == len_q - 1'b1;
    acc_wr    = ~send_q & ~soft_clr;
    mem_we    = data_wr & acc_wr;
    done      = send_q & tx_ready & last_beat & ~soft_clr;
  end

  always_comb begin
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    len_d  = len_q;
    snd_d  = snd_q;
    send_d = send_q;
    if (cnt_wr && acc_wr) begin
      cnt_d = (wdata <= 32'(FRAME_MAX)) ? wdata[CW-1:0] : '0;
      wr_d  = '0;
    end
    if (data_wr && acc_wr) begin
      wr_d = nxt_wr;
      if (hit) begin
        send_d = 1'b1;
        len_d  = nxt_wr;
        snd_d  = '0;
      end
    end
    if (send_q && tx_ready) begin
      if (last_beat) begin
        send_d = 1'b0;
        cnt_d  = '0;
        wr_d   = '0;
      end else begin
        snd_d = snd_q + 1'b1;
      end
    end
    if (soft_clr) begin
      cnt_d  = '0;
      wr_d   = '0;
      len_d  = '0;
      snd_d  = '0;
      send_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wr_q   <= '0;
      len_q  <= '0;
      snd_q  <= '0;
      send_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      len_q  <= len_d;
      snd_q  <= snd_d;
      send_q <= send_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_q] <= wdata[7:0];
  end

  assign tx_valid = send_q;
  assign tx_data  = send_q ? mem[snd_q] : 8'h00;
  assign tx_last  = send_q & last_beat;
  assign tx_cnt   = cnt_q;

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !soft_clr) |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R8
  tx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && (cnt_wr || data_wr) && !soft_clr) |=> $stable(cnt_q));

  // R9
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cnt_q == '0 && !tx_valid);

endmodule

// File: rtl/frame_port_nic.sv
module frame_port_nic
  import fpn_pkg::*;
#(
  parameter int unsigned FRAME_MAX = fpn_pkg::FRAME_MAX_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rxs_valid,
  input  logic [7:0]  rxs_data,
  input  logic        rxs_last,
  output logic        txs_valid,
  output logic [7:0]  txs_data,
  output logic        txs_last,
  input  logic        txs_ready
);

  localparam int unsigned CW = $clog2(FRAME_MAX + 1);

  logic          rst_sn;
  logic          wr_stb, rd_stb;
  logic          ctl_wr, ctl_rd, rx_take, txc_wr, txd_wr;
  logic          busy, soft_clr, rx_commit, tx_done;
  logic [31:0]   ctl_word;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [7:0]    rx_byte;
  logic [31:0]   rd_mux, rdata_q;

  fpn_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  always_comb begin
    wr_stb  = bus_sel &  bus_we;
    rd_stb  = bus_sel & ~bus_we;
    ctl_wr  = wr_stb & (bus_addr == OFS_IRQ_CTL);
    ctl_rd  = rd_stb & (bus_addr == OFS_IRQ_CTL);
    rx_take = rd_stb & (bus_addr == OFS_RX_DATA);
    txc_wr  = wr_stb & (bus_addr == OFS_TX_CNT);
    txd_wr  = wr_stb & (bus_addr == OFS_TX_DATA);
  end

  fpn_irq_ctl i_irq_ctl (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ctl_wr    (ctl_wr),
    .ctl_rd    (ctl_rd),
    .ctl_cmd   ({bus_wdata[31], bus_wdata[1], bus_wdata[0]}),
    .rx_commit (rx_commit),
    .tx_done   (tx_done),
    .busy      (busy),
    .irq       (irq),
    .ctl_word  (ctl_word),
    .soft_clr  (soft_clr)
  );

  fpn_rx_buf #(.FRAME_MAX(FRAME_MAX), .CW(CW)) i_rx_buf (
    .clk      (clk),
    .rst_n    (rst_sn),
    .soft_clr (soft_clr),
    .busy     (busy),
    .rx_valid (rxs_valid),
    .rx_data  (rxs_data),
    .rx_last  (rxs_last),
    .rd_take  (rx_take),
    .commit   (rx_commit),
    .rx_cnt   (rx_cnt),
    .rd_byte  (rx_byte)
  );

  fpn_tx_buf #(.FRAME_MAX(FRAME_MAX), .CW(CW)) i_tx_buf (
    .clk      (clk),
    .rst_n    (rst_sn),
    .soft_clr (soft_clr),
    .cnt_wr   (txc_wr),
    .data_wr  (txd_wr),
    .wdata    (bus_wdata),
    .tx_ready (txs_ready),
    .tx_valid (txs_valid),
    .tx_data  (txs_data),
    .tx_last  (txs_last),
    .done     (tx_done),
    .tx_cnt   (tx_cnt)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_ID_HI:   rd_mux = ID_HI_WORD;
      OFS_ID_LO:   rd_mux = ID_LO_WORD;
      OFS_BUSY:    rd_mux = {31'd0, busy};
      OFS_RX_CNT:  rd_mux = {{(32-CW){1'b0}}, rx_cnt};
      OFS_TX_CNT:  rd_mux = {{(32-CW){1'b0}}, tx_cnt};
      OFS_IRQ_CTL: rd_mux = ctl_word;
      OFS_RX_DATA: rd_mux = {24'd0, rx_byte};
      default:     rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R12
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ctl_rd |=> ((bus_rdata != 32'd0) == $past(irq)));

  // R13
  rx_noside_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rx_take && !rx_commit && !soft_clr) |=> rx_cnt == $past(rx_cnt));

endmodule

// File: tb/test_frame_port_nic.sv
`timescale 1ns/1ps
module test_frame_port_nic;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rxs_valid, rxs_last;
  logic [7:0]  rxs_data;
  logic        txs_valid, txs_last, txs_ready;
  logic [7:0]  txs_data;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] cap [2048];
  int cap_n   = 0;
  int last_at = -1;
  int last_n  = 0;

  always #2 clk = ~clk;

  frame_port_nic i_frame_port_nic (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rxs_valid(rxs_valid), .rxs_data(rxs_data), .rxs_last(rxs_last),
    .txs_valid(txs_valid), .txs_data(txs_data), .txs_last(txs_last), .txs_ready(txs_ready)
  );

  // {tag, op(1=wr,2=rd-check), addr, wdata, expected}
  localparam int NV = 23;
  localparam logic [79:0] VEC [NV] = '{
    // R2: identifier words, info, tx data, unmapped
    {8'd2, 2'd2, 6'h00, 32'h0, 32'h424E_4943},
    {8'd2, 2'd2, 6'h04, 32'h0, 32'h5052_5430},
    // R1: reset values
    {8'd1, 2'd2, 6'h08, 32'h0, 32'h1},
    {8'd1, 2'd2, 6'h0C, 32'h0, 32'h0},
    {8'd1, 2'd2, 6'h10, 32'h0, 32'h0},
    {8'd1, 2'd2, 6'h14, 32'h0, 32'h0},
    {8'd2, 2'd2, 6'h18, 32'h0, 32'h0},
    {8'd2, 2'd2, 6'h20, 32'h0, 32'h0},
    {8'd2, 2'd2, 6'h3C, 32'h0, 32'h0},
    // R2: writes to read-only offsets ignored
    {8'd2, 2'd1, 6'h08, 32'h0, 32'h0},
    {8'd2, 2'd2, 6'h08, 32'h0, 32'h1},
    {8'd2, 2'd1, 6'h00, 32'hFFFF_FFFF, 32'h0},
    {8'd2, 2'd2, 6'h00, 32'h0, 32'h424E_4943},
    // R7: transmit count range
    {8'd7, 2'd1, 6'h10, 32'd2000, 32'h0},
    {8'd7, 2'd2, 6'h10, 32'h0, 32'h0},
    {8'd7, 2'd1, 6'h10, 32'd1514, 32'h0},
    {8'd7, 2'd2, 6'h10, 32'h0, 32'd1514},
    {8'd7, 2'd1, 6'h10, 32'd1515, 32'h0},
    {8'd7, 2'd2, 6'h10, 32'h0, 32'h0},
    // R10: write of zero, busy follows flags
    {8'd10, 2'd1, 6'h14, 32'h0, 32'h0},
    {8'd10, 2'd2, 6'h08, 32'h0, 32'h0},
    {8'd10, 2'd2, 6'h14, 32'h0, 32'h0},
    {8'd12, 2'd2, 6'h0C, 32'h0, 32'h0}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] got;
    cpu_rd(a, got);
    check(got == exp, tag, $sformatf("read 0x%h", a), got, exp);
  endtask

  task automatic send_frame(input int len, input logic [7:0] st);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxs_valid = 1'b1;
      rxs_data  = 8'(st + i);
      rxs_last  = (i == len - 1);
    end
    @(negedge clk);
    rxs_valid = 1'b0; rxs_last = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    if (txs_valid && txs_ready) begin
      cap[cap_n] = txs_data;
      if (txs_last) begin
        last_at = cap_n;
        last_n++;
      end
      cap_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rxs_valid = 1'b0; rxs_last = 1'b0; rxs_data = '0; txs_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][71:70] == 2'd1) cpu_wr(VEC[k][69:64], VEC[k][63:32]);
      else rd_chk(VEC[k][69:64], VEC[k][31:0], $sformatf("R%0d vec%0d", VEC[k][79:72], k));
    end

    // R4 receive of a 4-byte frame, R12 irq
    send_frame(4, 8'h30);
    rd_chk(6'h0C, 32'd4, "R4");
    rd_chk(6'h14, 32'h2, "R4");
    rd_chk(6'h08, 32'h1, "R4");
    check(irq == 1'b1, "R12", "irq on rx done", 32'(irq), 32'h1);

    // R3 frame refused while busy
    send_frame(3, 8'h90);
    rd_chk(6'h0C, 32'd4, "R3");

    // R13 no side effect without select or on write
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 6'h1C;
    idle(3);
    cpu_wr(6'h1C, 32'h0);
    cpu_wr(6'h0C, 32'h7);
    rd_chk(6'h0C, 32'd4, "R13");

    // R6 byte read-out in order, then empty
    for (int i = 0; i < 4; i++) rd_chk(6'h1C, 32'(8'h30 + i), "R6");
    rd_chk(6'h1C, 32'h0, "R6");
    rd_chk(6'h0C, 32'h0, "R6");

    // R8 three-byte send, low byte only
    cap_n = 0; last_n = 0; last_at = -1;
    cpu_wr(6'h10, 32'd3);
    cpu_wr(6'h20, 32'h1A1);
    cpu_wr(6'h20, 32'h1A2);
    cpu_wr(6'h20, 32'h3A3);
    idle(8);
    check(cap_n == 3, "R8", "tx byte count", 32'(cap_n), 32'd3);
    check(cap[0] == 8'hA1 && cap[1] == 8'hA2 && cap[2] == 8'hA3, "R8", "tx bytes",
          {8'h0, cap[0], cap[1], cap[2]}, 32'h00A1A2A3);
    check(last_at == 2 && last_n == 1, "R8", "tx last position", 32'(last_at), 32'd2);
    // R9 after send
    rd_chk(6'h14, 32'h3, "R9");
    rd_chk(6'h10, 32'h0, "R9");

    // R10 priority: bit0 before bit1
    cpu_wr(6'h14, 32'h3);
    rd_chk(6'h14, 32'h2, "R10");
    rd_chk(6'h08, 32'h1, "R10");
    // R10 bit1 before bit31
    cpu_wr(6'h14, 32'h8000_0002);
    rd_chk(6'h14, 32'h0, "R10");
    rd_chk(6'h08, 32'h0, "R10");
    check(irq == 1'b0, "R12", "irq with no flags", 32'(irq), 32'h0);

    // R8 backpressure and ignored writes during send
    cap_n = 0; last_n = 0; last_at = -1;
    @(negedge clk); txs_ready = 1'b0;
    cpu_wr(6'h10, 32'd2);
    cpu_wr(6'h20, 32'h55);
    cpu_wr(6'h20, 32'h66);
    cpu_wr(6'h20, 32'h77);
    cpu_wr(6'h10, 32'd9);
    rd_chk(6'h10, 32'd2, "R8");
    check(txs_valid == 1'b1 && txs_data == 8'h55, "R8", "held byte",
          {23'd0, txs_valid, txs_data}, 32'h155);
    @(negedge clk); txs_ready = 1'b1;
    idle(6);
    check(cap_n == 2 && cap[0] == 8'h55 && cap[1] == 8'h66, "R8", "tx after stall",
          {8'(cap_n), 8'h0, cap[0], cap[1]}, 32'h02005566);
    rd_chk(6'h14, 32'h1, "R9");
    cpu_wr(6'h14, 32'h1);

    // R5 overlong frame dropped
    send_frame(1514, 8'h00);
    rd_chk(6'h14, 32'h0, "R5");
    rd_chk(6'h0C, 32'h0, "R5");
    // R4 longest accepted frame
    send_frame(1513, 8'h10);
    rd_chk(6'h0C, 32'd1513, "R4");
    rd_chk(6'h14, 32'h2, "R4");
    rd_chk(6'h1C, 32'h10, "R6");
    rd_chk(6'h1C, 32'h11, "R6");
    rd_chk(6'h0C, 32'd1511, "R6");

    // R10 soft reset, R11 read clears test bit
    cpu_wr(6'h14, 32'h8000_0000);
    check(irq == 1'b1, "R12", "irq on test bit", 32'(irq), 32'h1);
    rd_chk(6'h14, 32'h8000_0000, "R11");
    rd_chk(6'h14, 32'h0, "R11");
    check(irq == 1'b0, "R12", "irq after test clear", 32'(irq), 32'h0);
    rd_chk(6'h0C, 32'h0, "R10");
    rd_chk(6'h08, 32'h1, "R10");

    // R8 count of zero sends at 1514 bytes
    cap_n = 0; last_n = 0; last_at = -1;
    cpu_wr(6'h10, 32'd0);
    for (int i = 0; i < 1514; i++) cpu_wr(6'h20, 32'(i));
    idle(1530);
    check(cap_n == 1514, "R8", "full frame length", 32'(cap_n), 32'd1514);
    check(last_at == 1513, "R8", "full frame last", 32'(last_at), 32'd1513);
    check(cap[1000] == 8'(1000), "R8", "full frame byte", 32'(cap[1000]), 32'(8'(1000)));
    rd_chk(6'h14, 32'h1, "R9");

    cpu_rd(6'h00, r);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule